// File: doc/BRIEF.md
# Word-Counting Disk DMA Engine

This block moves 16-bit words between system memory and the byte-wide data port of a disk controller. Software programs it through two registers. The count/control register holds a word count, a direction bit and an enable bit. The address register holds a word address and is loaded one half at a time from the CPU address lines. Once the engine is enabled, it builds each word from two byte accesses to the controller, or splits each word into two byte accesses. Every byte access waits for the controller's data request line.

The count runs upward. The first cycle after an enabling write adds one to the count before any data moves. Words then move while the count is below the terminal value 2^CNT_W. When the count reaches that value, the engine clears the count, turns itself off and pulses `done` for one clock. A parameter limits how many words the engine moves in one hold of the memory bus. After that many words, `bus_hold` drops for one cycle before the engine continues.

Top module: `dskdma_top`

## Requirements
- R1: The count/control register takes its count from bits CNT_W-1:0, its direction from bit 14 (1 = memory to device, 0 = device to memory) and its enable from bit 15. A write with bit 15 clear leaves the engine idle and holds the written count.
- R2: In the first cycle after a write that sets bit 15, the count increases by one and no byte or memory access takes place. A written count of 2^CNT_W-1 therefore moves no words.
- R3: An enabled engine moves 2^CNT_W-1-n words for a written count n. When the count reaches 2^CNT_W, the count returns to zero, the enable clears and no further access occurs.
- R4: `done` is high for exactly one clock per completed transfer.
- R5: The memory byte address equals the word address shifted left by one. The word address rises by one after each word, and a carry from bit 7 propagates into the upper bits.
- R6: An address-register write with `reg_addr[14]`=1 loads word-address bits ADDR_W-1:8 from `reg_addr[13:0]`. With `reg_addr[14]`=0 it loads bits 7:0 from `reg_addr[7:0]`. The other group keeps its value.
- R7: In the device-to-memory direction, the first byte read becomes bits 15:8 and the second becomes bits 7:0 of the word written to memory.
- R8: In the memory-to-device direction, each word is read from memory and written to the device as bits 15:8 first, then bits 7:0.
- R9: `dev_rd` and `dev_wr` are only asserted while `dev_drq` is high. While `dev_drq` is low the engine stalls, and it resumes when `dev_drq` returns.
- R10: `reg_rdata` returns the count in bits CNT_W-1:0, 1 in bit 15 (an error flag that always reads inactive) and 0 in all other bits.
- R11: Within one continuous high period of `bus_hold`, at most BURST_WORDS memory accesses complete. After BURST_WORDS words, `bus_hold` is low for one cycle before the next word, unless that word was the last one.
- R12: After reset the readback is 0x8000, and `done`, `bus_hold`, `mem_req`, `dev_rd` and `dev_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = count/control register, 1 = address register |
| reg_addr | input | SEL_BIT+1 | CPU address lines for address-register loads |
| reg_wdata | input | 16 | Write data for the count/control register |
| reg_rdata | output | 16 | Count readback |
| done | output | 1 | One-clock pulse at transfer completion |
| bus_hold | output | 1 | Engine holds the memory bus |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W+1 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory acknowledge |
| dev_drq | input | 1 | Controller data request |
| dev_rd | output | 1 | Byte read strobe; data sampled in the same cycle |
| dev_rdata | input | 8 | Controller read data |
| dev_wr | output | 1 | Byte write strobe |
| dev_wdata | output | 8 | Controller write data |

## Verification
The bench sweeps every written count in both directions on a 6-bit count. Each count n must move exactly 63-n words. An engine that skipped the priming increment would move one word too many, and one that compared against the wrong terminal value would never raise `done` or would run past the end. The sweep starts at low address bytes that force a carry into the upper group, and it runs with a data request line that drops at irregular times. A byte-order swap, a lost carry or a strobe issued without a request shows up as corrupted memory or device data. The bench counts every fall of `bus_hold` against the exact number of expected pauses, so a burst limit that is off by one, or a pause that never happens, changes that count.

// File: rtl/dskdma_pkg.sv
// Package: shared state encoding and register bit positions for the disk DMA engine.
package dskdma_pkg;

    // Sequencer states: one decision state, one pause state, and the byte/word phases.
    typedef enum logic [2:0] {
        ST_CHECK   = 3'd0,
        ST_PAUSE   = 3'd1,
        ST_DEV_HI  = 3'd2,
        ST_DEV_LO  = 3'd3,
        ST_MEM_WR  = 3'd4,
        ST_MEM_RD  = 3'd5,
        ST_OUT_HI  = 3'd6,
        ST_OUT_LO  = 3'd7
    } dma_state_t;

    // Control field positions in the count/control register.
    localparam int CTRL_DIR_BIT = 14;
    localparam int CTRL_EN_BIT  = 15;
    localparam int RD_FLAG_BIT  = 15;

endpackage

// File: rtl/dskdma_regs.sv
// Module: dskdma_regs
// Holds the count/control state and the word address register.
// Assumes: CNT_W <= 14, ADDR_W-LO_W <= SEL_BIT. A CPU write takes priority
// over any internal update in the same cycle.
module dskdma_regs
    import dskdma_pkg::*;
#(
    parameter int CNT_W   = 14,
    parameter int ADDR_W  = 22,
    parameter int LO_W    = 8,
    parameter int SEL_BIT = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_wr,
    input  logic              adr_wr,
    input  logic [SEL_BIT:0]  wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              prime,
    input  logic              step,
    input  logic              finish,
    output logic [CNT_W:0]    count,
    output logic              dir,
    output logic              en,
    output logic              armed,
    output logic [ADDR_W-1:0] waddr,
    output logic [15:0]       rdata
);
    localparam int HI_W = ADDR_W - LO_W;

    // Count, direction, enable and one-shot arm flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            dir   <= 1'b0;
            en    <= 1'b0;
            armed <= 1'b0;
        end else if (cnt_wr) begin
            count <= {1'b0, wr_data[CNT_W-1:0]};
            dir   <= wr_data[CTRL_DIR_BIT];
            en    <= wr_data[CTRL_EN_BIT];
            armed <= wr_data[CTRL_EN_BIT];
        end else if (finish) begin
            count <= '0;
            en    <= 1'b0;
        end else if (prime) begin
            count <= count + 1'b1;
            armed <= 1'b0;
        end else if (step) begin
            count <= count + 1'b1;
        end
    end

    // Word address: group loads from the CPU address lines, increment per word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waddr <= '0;
        end else if (adr_wr) begin
            if (wr_addr[SEL_BIT])
                waddr[ADDR_W-1:LO_W] <= wr_addr[HI_W-1:0];
            else
                waddr[LO_W-1:0] <= wr_addr[LO_W-1:0];
        end else if (step) begin
            waddr <= waddr + 1'b1;
        end
    end

    // Readback: count bits with the error flag forced inactive.
    always_comb begin
        rdata              = '0;
        rdata[CNT_W-1:0]   = count[CNT_W-1:0];
        rdata[RD_FLAG_BIT] = 1'b1;
    end

endmodule

// File: rtl/dskdma_xfer.sv
// Module: dskdma_xfer
// Sequencer: primes the count, checks the terminal value and burst limit,
// and runs the byte and word phases in either direction.
// Assumes: memory holds mem_req until mem_ack; device read data is valid in
// the cycle dev_rd is high. A count-register write (abort) returns to ST_CHECK.
module dskdma_xfer
    import dskdma_pkg::*;
#(
    parameter int CNT_W       = 14,
    parameter int ADDR_W      = 22,
    parameter int BURST_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              en,
    input  logic              armed,
    input  logic              dir,
    input  logic [CNT_W:0]    count,
    input  logic [ADDR_W-1:0] waddr,
    output logic              prime,
    output logic              step,
    output logic              finish,
    output logic              done,
    output logic              bus_hold,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W:0]   mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    input  logic              mem_ack,
    input  logic              dev_drq,
    output logic              dev_rd,
    input  logic [7:0]        dev_rdata,
    output logic              dev_wr,
    output logic [7:0]        dev_wdata
);
    localparam logic [CNT_W:0] TERM = {1'b1, {CNT_W{1'b0}}};
    localparam int             BW   = $clog2(BURST_WORDS + 1);
    localparam logic [BW-1:0]  BMAX = BW'(BURST_WORDS);

    dma_state_t    state, nxt;
    logic [15:0]   word_q;
    logic [BW-1:0] burst_q;

    // Next-state and strobe decode.
    always_comb begin
        nxt       = state;
        prime     = 1'b0;
        step      = 1'b0;
        finish    = 1'b0;
        done      = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        dev_rd    = 1'b0;
        dev_wr    = 1'b0;
        dev_wdata = '0;
        unique case (state)
            ST_CHECK: begin
                if (en) begin
                    if (armed) begin
                        prime = 1'b1;
                    end else if (count == TERM) begin
                        finish = 1'b1;
                        done   = 1'b1;
                    end else if (burst_q == BMAX) begin
                        nxt = ST_PAUSE;
                    end else begin
                        nxt = dir ? ST_MEM_RD : ST_DEV_HI;
                    end
                end
            end
            ST_PAUSE: nxt = ST_CHECK;
            ST_DEV_HI: begin
                if (dev_drq) begin
                    dev_rd = 1'b1;
                    nxt    = ST_DEV_LO;
                end
            end
            ST_DEV_LO: begin
                if (dev_drq) begin
                    dev_rd = 1'b1;
                    nxt    = ST_MEM_WR;
                end
            end
            ST_MEM_WR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    step = 1'b1;
                    nxt  = ST_CHECK;
                end
            end
            ST_MEM_RD: begin
                mem_req = 1'b1;
                if (mem_ack) nxt = ST_OUT_HI;
            end
            ST_OUT_HI: begin
                dev_wdata = word_q[15:8];
                if (dev_drq) begin
                    dev_wr = 1'b1;
                    nxt    = ST_OUT_LO;
                end
            end
            ST_OUT_LO: begin
                dev_wdata = word_q[7:0];
                if (dev_drq) begin
                    dev_wr = 1'b1;
                    step   = 1'b1;
                    nxt    = ST_CHECK;
                end
            end
            default: nxt = ST_CHECK;
        endcase
    end

    assign mem_addr  = {waddr, 1'b0};
    assign mem_wdata = word_q;
    assign bus_hold  = en && (state != ST_PAUSE);

    // State register with abort back to the decision state.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) state <= ST_CHECK;
        else                 state <= nxt;
    end

    // Word assembly: high byte first from the device, or whole word from memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            if (state == ST_DEV_HI && dev_drq) word_q[15:8] <= dev_rdata;
            if (state == ST_DEV_LO && dev_drq) word_q[7:0]  <= dev_rdata;
            if (state == ST_MEM_RD && mem_ack) word_q       <= mem_rdata;
        end
    end

    // Words moved in the current bus hold; cleared by a pause, finish or abort.
    always_ff @(posedge clk) begin
        if (!rst_n || abort || finish || state == ST_PAUSE) burst_q <= '0;
        else if (step)                                       burst_q <= burst_q + 1'b1;
    end

endmodule

// File: rtl/dskdma_top.sv
// Module: dskdma_top
// Disk DMA engine top: decodes the CPU register port and joins the register
// block to the transfer sequencer.
// Assumes: one register write per cycle; reg_sel picks the target register.
module dskdma_top
    import dskdma_pkg::*;
#(
    parameter int CNT_W       = 14,
    parameter int ADDR_W      = 22,
    parameter int LO_W        = 8,
    parameter int SEL_BIT     = 14,
    parameter int BURST_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [SEL_BIT:0]  reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              done,
    output logic              bus_hold,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W:0]   mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    input  logic              mem_ack,
    input  logic              dev_drq,
    output logic              dev_rd,
    input  logic [7:0]        dev_rdata,
    output logic              dev_wr,
    output logic [7:0]        dev_wdata
);
    logic              cnt_wr, adr_wr;
    logic              prime, step, finish;
    logic [CNT_W:0]    count;
    logic              dir, en, armed;
    logic [ADDR_W-1:0] waddr;

    // Register-port decode.
    assign cnt_wr = reg_wr && !reg_sel;
    assign adr_wr = reg_wr &&  reg_sel;

    dskdma_regs #(
        .CNT_W(CNT_W), .ADDR_W(ADDR_W), .LO_W(LO_W), .SEL_BIT(SEL_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cnt_wr(cnt_wr), .adr_wr(adr_wr),
        .wr_addr(reg_addr), .wr_data(reg_wdata),
        .prime(prime), .step(step), .finish(finish),
        .count(count), .dir(dir), .en(en), .armed(armed),
        .waddr(waddr), .rdata(reg_rdata)
    );

    dskdma_xfer #(
        .CNT_W(CNT_W), .ADDR_W(ADDR_W), .BURST_WORDS(BURST_WORDS)
    ) u_xfer (
        .clk(clk), .rst_n(rst_n), .abort(cnt_wr),
        .en(en), .armed(armed), .dir(dir), .count(count), .waddr(waddr),
        .prime(prime), .step(step), .finish(finish), .done(done),
        .bus_hold(bus_hold),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .dev_drq(dev_drq), .dev_rd(dev_rd), .dev_rdata(dev_rdata),
        .dev_wr(dev_wr), .dev_wdata(dev_wdata)
    );

endmodule

// File: rtl/dskdma_chk.sv
// Module: dskdma_chk
// Protocol checker for dskdma_top, attached by bind. Observes ports only.
module dskdma_chk #(
    parameter int ADDR_W      = 22,
    parameter int BURST_WORDS = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic            reg_sel,
    input logic [15:0]     reg_rdata,
    input logic            done,
    input logic            bus_hold,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_ack,
    input logic [ADDR_W:0] mem_addr,
    input logic            dev_rd,
    input logic            dev_wr,
    input logic            dev_drq
);
    int              hold_words;
    logic [ADDR_W:0] prev_addr;
    logic            prev_ok;

    // Count completed memory accesses within one bus hold.
    always_ff @(posedge clk) begin
        if (!rst_n || !bus_hold)     hold_words <= 0;
        else if (mem_req && mem_ack) hold_words <= hold_words + 1;
    end

    // Remember the last completed access address until software reprograms.
    always_ff @(posedge clk) begin
        if (!rst_n || reg_wr) begin
            prev_ok   <= 1'b0;
            prev_addr <= '0;
        end else if (mem_req && mem_ack) begin
            prev_ok   <= 1'b1;
            prev_addr <= mem_addr;
        end
    end

    a_r9_drq_qual: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rd || dev_wr) |-> dev_drq);

    a_r8_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_rd && dev_wr) && !(mem_req && (dev_rd || dev_wr)));

    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !reg_wr) |=> (!bus_hold && reg_rdata == 16'h8000));

    a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !reg_wr) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r11_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
        hold_words <= BURST_WORDS);

    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && prev_ok && !(reg_wr && reg_sel))
            |-> (mem_addr == (ADDR_W+1)'(prev_addr + 2)));

endmodule

bind dskdma_top dskdma_chk #(
    .ADDR_W(ADDR_W), .BURST_WORDS(BURST_WORDS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_rdata(reg_rdata), .done(done), .bus_hold(bus_hold),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_drq(dev_drq)
);

// File: tb/tb_dskdma_top.sv
// Bench: sweeps every written count in both directions on a small count width,
// with behavioural memory and device models and arithmetic expectations.
module tb_dskdma_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 6;
    localparam int ADDR_W     = 22;
    localparam int BURST      = 5;
    localparam int TERM       = 1 << CNT_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_sel = 1'b0;
    logic [14:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        done, bus_hold, mem_req, mem_we, dev_rd, dev_wr;
    logic [ADDR_W:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        dev_drq = 1'b0;
    logic [7:0]  dev_rdata;
    logic [7:0]  dev_wdata;

    dskdma_top #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .LO_W(8), .SEL_BIT(14),
                 .BURST_WORDS(BURST)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .done(done), .bus_hold(bus_hold), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .dev_drq(dev_drq), .dev_rd(dev_rd),
        .dev_rdata(dev_rdata), .dev_wr(dev_wr), .dev_wdata(dev_wdata));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Model state
    logic [15:0] mem [128];
    logic [7:0]  src [256];
    logic [7:0]  sink [256];
    logic [ADDR_W:0] beat_addr [256];
    int beats = 0, src_ptr = 0, wptr = 0, dones = 0, strobe_err = 0;
    int run_words = 0, max_run = 0, falls = 0;
    logic prev_hold = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    int drq_mode = 0;
    int n_chk = 0, n_fail = 0;

    assign dev_rdata = src[src_ptr % 256];

    // Memory, device and monitor models, all updated with nonblocking writes.
    initial begin
        forever begin
            @(posedge clk);
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                if (mem_we) mem[mem_addr[7:1]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[7:1]];
            end else begin
                mem_ack <= 1'b0;
            end
            if (mem_req && mem_ack) begin
                beat_addr[beats % 256] <= mem_addr;
                beats <= beats + 1;
            end
            if (dev_rd) begin
                if (!dev_drq) strobe_err <= strobe_err + 1;
                src_ptr <= src_ptr + 1;
            end
            if (dev_wr) begin
                if (!dev_drq) strobe_err <= strobe_err + 1;
                sink[wptr % 256] <= dev_wdata;
                wptr <= wptr + 1;
            end
            if (done) dones <= dones + 1;
            if (!bus_hold) run_words <= 0;
            else if (mem_req && mem_ack) run_words <= run_words + 1;
            if (run_words > max_run) max_run <= run_words;
            if (prev_hold && !bus_hold) falls <= falls + 1;
            prev_hold <= bus_hold;
            lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            dev_drq <= (drq_mode == 0) ? 1'b1 :
                       (drq_mode == 1) ? (lfsr[0] | lfsr[2]) : 1'b0;
        end
    end

    task automatic chk(input string req, input bit ok, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input bit sel, input logic [14:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic set_addr(input int hi, input int lo);
        reg_write(1'b1, 15'((1 << 14) | hi), 16'h0);
        reg_write(1'b1, 15'(lo & 255), 16'h0);
    endtask

    // One full transfer: program, wait for done, check everything against arithmetic.
    task automatic run(input bit dir, input int n, input int base, input int mode);
        int sb, ss, sw, sd, sf, w, k, bad, first_a, first_e, pauses;
        logic [ADDR_W:0] ea;
        for (int i = 0; i < 256; i++) src[i] = 8'((i * 37) + (n * 5) + 11);
        for (int j = 0; j < 128; j++) mem[j] = 16'(((j * 1103) + (n * 17)) ^ 'h5a3c);
        drq_mode = mode;
        @(negedge clk);
        sb = beats; ss = src_ptr; sw = wptr; sd = dones; sf = falls;
        reg_write(1'b0, '0, 16'(32'h8000 | (32'(dir) << 14) | n));
        k = 0;
        while (dones == sd && k < 3000) begin @(negedge clk); k++; end
        repeat (20) @(negedge clk);
        w = TERM - 1 - n;
        chk("R4 done count", dones - sd == 1, dones - sd, 1);
        chk("R3 word count", beats - sb == w, beats - sb, w);
        chk("R10 readback after finish", reg_rdata == 16'h8000, reg_rdata, 16'h8000);
        if (dir) chk("R8 device bytes", wptr - sw == 2 * w, wptr - sw, 2 * w);
        else     chk("R7 device bytes", src_ptr - ss == 2 * w, src_ptr - ss, 2 * w);
        chk("R9 strobe without drq", strobe_err == 0, strobe_err, 0);
        bad = 0; first_a = 0; first_e = 0;
        for (int j = 0; j < w; j++) begin
            ea = {ADDR_W'(base + j), 1'b0};
            if (beat_addr[(sb + j) % 256] != ea) begin
                if (bad == 0) begin first_a = int'(beat_addr[(sb + j) % 256]); first_e = int'(ea); end
                bad++;
            end
        end
        chk("R5 address sequence", bad == 0, first_a, first_e);
        bad = 0;
        for (int j = 0; j < w; j++) begin
            logic [15:0] got, exp;
            if (dir) begin
                got = {sink[(sw + 2*j) % 256], sink[(sw + 2*j + 1) % 256]};
                exp = mem[(base + j) % 128];
            end else begin
                got = mem[(base + j) % 128];
                exp = {src[(ss + 2*j) % 256], src[(ss + 2*j + 1) % 256]};
            end
            if (got != exp) begin
                if (bad == 0) begin first_a = int'(got); first_e = int'(exp); end
                bad++;
            end
        end
        if (dir) chk("R8 word data hi-lo", bad == 0, first_a, first_e);
        else     chk("R7 word data hi-lo", bad == 0, first_a, first_e);
        pauses = (w > 0) ? ((w - 1) / BURST) + 1 : 1;
        chk("R11 bus_hold drops", falls - sf == pauses, falls - sf, pauses);
    endtask

    initial begin
        int base, sb, ss, sd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset readback", reg_rdata == 16'h8000, reg_rdata, 16'h8000);
        chk("R12 reset outputs", {done, bus_hold, mem_req, dev_rd, dev_wr} == 5'b0,
            {done, bus_hold, mem_req, dev_rd, dev_wr}, 0);

        // R1/R10: a write without enable leaves the engine idle; bit 14 never reads back.
        sb = beats; sd = dones;
        reg_write(1'b0, '0, 16'h4000 | 16'd25);
        repeat (10) @(negedge clk);
        chk("R1 disabled count held", reg_rdata == 16'h8019, reg_rdata, 16'h8019);
        chk("R1 disabled no activity", beats == sb && dones == sd && !bus_hold, beats - sb, 0);

        // R2/R9: priming increment, then a stall while drq is held low.
        set_addr(3, 8'hF0);
        sb = beats; ss = src_ptr; sd = dones;
        drq_mode = 2;
        reg_write(1'b0, '0, 16'h8000 | 16'd10);
        repeat (5) @(negedge clk);
        chk("R2 prime increment", reg_rdata == 16'h800B, reg_rdata, 16'h800B);
        repeat (30) @(negedge clk);
        chk("R9 stall no strobes", src_ptr == ss && beats == sb, src_ptr - ss, 0);
        chk("R9 stall count held", reg_rdata == 16'h800B, reg_rdata, 16'h800B);
        drq_mode = 0;
        while (dones == sd) @(negedge clk);
        repeat (5) @(negedge clk);
        chk("R9 resume word count", beats - sb == TERM - 11, beats - sb, TERM - 11);
        chk("R6 carry address", beat_addr[(sb + 20) % 256] == {22'h0004_04, 1'b0},
            beat_addr[(sb + 20) % 256], {22'h0004_04, 1'b0});

        // R6: reloading only the low group keeps the high group.
        set_addr(12'h155, 8'h10);
        reg_write(1'b1, 15'h0020, 16'h0);
        run(1'b0, TERM - 4, 32'h15520, 0);

        // Sweep every count in both directions with varied addresses and drq patterns.
        for (int d = 0; d < 2; d++) begin
            for (int n = 0; n < TERM; n++) begin
                int hi, lo;
                hi = (n * 3 + d) & 16'h3FFF;
                lo = (n * 29 + 200) & 255;
                base = (hi << 8) | lo;
                set_addr(hi, lo);
                run(d[0], n, base, (n % 3 == 0) ? 0 : 1);
            end
        end
        chk("R11 max words per hold", max_run <= BURST, max_run, BURST);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule